// File: doc/BRIEF.md
# Matching Pursuit Channel Estimator

This block estimates a sparse multipath channel from one received spread-spectrum symbol. It uses greedy matching pursuit. Software or a neighbouring block first loads four arrays through an indexed write port:

- the received sample vector;
- a signal matrix whose columns are the chip waveform shifted to each candidate path delay;
- the Gram matrix of that signal matrix;
- the reciprocals of the Gram diagonal, so that no divider is needed.

A start pulse launches the estimate. The block first correlates every candidate delay against the received samples. It then repeats one step a requested number of times. In each step it removes the contribution of the path found in the previous step from the correlation vector. It scores every delay by the energy that delay would capture. It picks the best delay that has not yet been used and reports that delay with its coefficient.

The datapath is fully serial. One filter-and-cancel cell and one multiply-accumulate unit are reused for every delay. Each operand is read from a memory that can map onto block RAM. The defaults use a small geometry (32 samples, 16 delays). Both dimensions are parameters, so the nominal 224-sample, 112-delay configuration is a matter of parameter values.

Top module: `mp_estimator`

## Requirements
- R1: While reset is high and in the first cycle after reset is released, `path_valid` and `done` are low.
- R2: A write with `wr_en` high while the block is idle stores `wr_data` into the array picked by `wr_sel`. The codes and addresses are:
  - code 0: received sample n, at address n;
  - code 1: signal matrix row n, column i, at address n*ND+i;
  - code 2: Gram element row k, column q, at address k*ND+q;
  - code 3: reciprocal k, at address k.
  Writes issued while an estimate is running are discarded and do not change any result.
- R3: Each correlation is V_i = sat(( sum over n of S[n][i]*r[n] ) >>> FRAC). Here sat clamps to the signed W-bit range.
- R4: From the second step onward, every V_k first becomes sat(V_k - ((f_p*A[k][p]) >>> FRAC)). Here p is the delay chosen in the previous step and f_p is its coefficient. The first step skips this update.
- R5: In each step, delay k gets gain g_k = sat((V_k*a_k) >>> FRAC) and score Q_k = V_k*g_k. Q_k is a signed product at full 2W width.
- R6: Each step chooses the delay with the largest score among delays not yet chosen in this estimate. On equal scores the lowest index wins. No delay is reported twice in one estimate.
- R7: Each chosen delay is reported by a one-cycle `path_valid` pulse carrying `path_idx` and `path_coef`. `path_coef` equals that delay's gain in the choosing step. Exactly min(n_paths, ND) paths are reported.
- R8: `done` is a one-cycle pulse in the cycle after the last `path_valid`. With `n_paths` of 0, `done` pulses once after the correlations and no path is reported.
- R9: A `start` pulse while an estimate is running is ignored. It produces no extra path and no extra `done`.
- R10: Every stored correlation, gain and reported coefficient saturates at the signed W-bit limits instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an estimate when idle |
| n_paths | input | $clog2(ND+1) | Paths to estimate, sampled at start |
| wr_en | input | 1 | Array write strobe |
| wr_sel | input | 2 | Array select (0 samples, 1 signal matrix, 2 Gram, 3 reciprocals) |
| wr_addr | input | $clog2(max(NS*ND, ND*ND)) | Write address inside the selected array |
| wr_data | input | W | Signed write data |
| path_valid | output | 1 | One-cycle strobe for a reported path |
| path_idx | output | $clog2(ND) | Chosen delay index |
| path_coef | output | W | Signed coefficient of the chosen delay |
| done | output | 1 | One-cycle end-of-estimate pulse |

## Verification
Every internal error shows up in the reported coefficient sequence, but with different delays:

- A wrong correlation, gain or saturation bound changes the first reported coefficient or index. That report arrives one step after the correlation phase.
- A fault in the cancellation update, such as a wrong Gram column or a cancel applied on the first step, only appears from the second reported path onward.
- A damaged exclusion bit or tie rule shows up as a repeated or out-of-order index, possibly only late in a long estimate.

For this reason the bench compares every reported path of every run against an independent model, including runs that ask for all delays. A leak of port writes into a running estimate only appears when the affected values are consumed. The bench therefore compares a disturbed run and a rerun after it against the undisturbed expectation.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CORR,
    ST_SCAN,
    ST_EMIT,
    ST_FIN
  } mp_state_e;

  typedef enum logic [1:0] {
    SEL_RX    = 2'd0,
    SEL_SIG   = 2'd1,
    SEL_GRAM  = 2'd2,
    SEL_RECIP = 2'd3
  } mp_sel_e;
endpackage

// File: rtl/mp_ram.sv
module mp_ram #(
  parameter int W     = 10,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mp_fc.sv
module mp_fc #(
  parameter int W    = 10,
  parameter int FRAC = 8
) (
  input  logic signed [W-1:0]   v_in,
  input  logic signed [W-1:0]   gram,
  input  logic signed [W-1:0]   f_prev,
  input  logic signed [W-1:0]   recip,
  input  logic                  skip_cancel,
  output logic signed [W-1:0]   v_out,
  output logic signed [W-1:0]   gain,
  output logic signed [2*W-1:0] metric
);
  localparam int XW = 2 * W + 1;
  localparam int HI = 2 ** (W - 1) - 1;
  localparam int LO = -(2 ** (W - 1));

  function automatic logic signed [W-1:0] sat_x(input logic signed [XW-1:0] x);
    if (x > XW'(HI))      return W'(HI);
    else if (x < XW'(LO)) return W'(LO);
    else                  return x[W-1:0];
  endfunction

  logic signed [2*W-1:0] cancel_p, cancel_sh, gain_p, gain_sh;
  logic signed [XW-1:0]  diff;

  always_comb begin
    cancel_p  = f_prev * gram;
    cancel_sh = cancel_p >>> FRAC;
    diff      = XW'(v_in) - XW'(cancel_sh);
    v_out     = skip_cancel ? v_in : sat_x(diff);
    gain_p    = v_out * recip;
    gain_sh   = gain_p >>> FRAC;
    gain      = sat_x(XW'(gain_sh));
    metric    = v_out * gain;
  end
endmodule

// File: rtl/mp_argmax.sv
module mp_argmax #(
  parameter int W  = 10,
  parameter int IW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  upd_en,
  input  logic [IW-1:0]         idx,
  input  logic                  excluded,
  input  logic signed [2*W-1:0] metric,
  input  logic signed [W-1:0]   gain,
  output logic [IW-1:0]         best_idx,
  output logic signed [W-1:0]   best_gain
);
  logic                  have;
  logic signed [2*W-1:0] best_m;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have      <= 1'b0;
      best_m    <= '0;
      best_idx  <= '0;
      best_gain <= '0;
    end else if (upd_en && !excluded && (!have || metric > best_m)) begin
      have      <= 1'b1;
      best_m    <= metric;
      best_idx  <= idx;
      best_gain <= gain;
    end
  end
endmodule

// File: rtl/mp_estimator.sv
module mp_estimator
  import mp_pkg::*;
#(
  parameter int ND   = 16,
  parameter int NS   = 32,
  parameter int W    = 10,
  parameter int FRAC = 8,
  localparam int IW   = (ND > 1) ? $clog2(ND) : 1,
  localparam int SW   = (NS > 1) ? $clog2(NS) : 1,
  localparam int NPW  = $clog2(ND + 1),
  localparam int SDEP = NS * ND,
  localparam int ADEP = ND * ND,
  localparam int MAXD = (SDEP > ADEP) ? SDEP : ADEP,
  localparam int WAW  = $clog2(MAXD),
  localparam int SAW  = $clog2(SDEP),
  localparam int GAW  = $clog2(ADEP)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [NPW-1:0]      n_paths,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [WAW-1:0]      wr_addr,
  input  logic signed [W-1:0] wr_data,
  output logic                path_valid,
  output logic [IW-1:0]       path_idx,
  output logic signed [W-1:0] path_coef,
  output logic                done
);
  localparam int ACCW = 2 * W + SW + 1;
  localparam int HI   = 2 ** (W - 1) - 1;
  localparam int LO   = -(2 ** (W - 1));

  function automatic logic signed [W-1:0] sat_acc(input logic signed [ACCW-1:0] x);
    if (x > ACCW'(HI))      return W'(HI);
    else if (x < ACCW'(LO)) return W'(LO);
    else                    return x[W-1:0];
  endfunction

  mp_state_e state;
  logic            phase, first;
  logic [IW-1:0]   cnt_k, qprev;
  logic [SW-1:0]   smp_n;
  logic [NPW-1:0]  np_r, jcnt;
  logic [ND-1:0]   chosen;
  logic signed [W-1:0] fprev;
  logic signed [ACCW-1:0] acc, acc_next;
  logic signed [2*W-1:0]  mf_prod;

  logic signed [W-1:0] r_q, s_q, g_q, a_q, v_q, v_wdata, fc_v, fc_g;
  logic signed [2*W-1:0] fc_m;
  logic [IW-1:0]       best_idx;
  logic signed [W-1:0] best_gain;
  logic                idle, v_we;
  logic [SAW-1:0]      sig_raddr;
  logic [GAW-1:0]      gram_raddr;

  assign idle       = (state == ST_IDLE);
  assign sig_raddr  = SAW'(smp_n) * SAW'(ND) + SAW'(cnt_k);
  assign gram_raddr = GAW'(cnt_k) * GAW'(ND) + GAW'(qprev);

  // operand memories, loaded only while idle
  mp_ram #(.W(W), .DEPTH(NS)) u_rx (
    .clk(clk), .we(wr_en && idle && wr_sel == SEL_RX),
    .waddr(wr_addr[SW-1:0]), .wdata(wr_data), .raddr(smp_n), .rdata(r_q));
  mp_ram #(.W(W), .DEPTH(SDEP)) u_sig (
    .clk(clk), .we(wr_en && idle && wr_sel == SEL_SIG),
    .waddr(wr_addr[SAW-1:0]), .wdata(wr_data), .raddr(sig_raddr), .rdata(s_q));
  mp_ram #(.W(W), .DEPTH(ADEP)) u_gram (
    .clk(clk), .we(wr_en && idle && wr_sel == SEL_GRAM),
    .waddr(wr_addr[GAW-1:0]), .wdata(wr_data), .raddr(gram_raddr), .rdata(g_q));
  mp_ram #(.W(W), .DEPTH(ND)) u_recip (
    .clk(clk), .we(wr_en && idle && wr_sel == SEL_RECIP),
    .waddr(wr_addr[IW-1:0]), .wdata(wr_data), .raddr(cnt_k), .rdata(a_q));

  // correlation vector
  always_comb begin
    mf_prod  = r_q * s_q;
    acc_next = acc + ACCW'(mf_prod);
    v_wdata  = (state == ST_CORR) ? sat_acc(acc_next >>> FRAC) : fc_v;
    v_we     = phase && ((state == ST_SCAN) ||
                         (state == ST_CORR && smp_n == SW'(NS - 1)));
  end

  mp_ram #(.W(W), .DEPTH(ND)) u_corr (
    .clk(clk), .we(v_we), .waddr(cnt_k), .wdata(v_wdata),
    .raddr(cnt_k), .rdata(v_q));

  mp_fc #(.W(W), .FRAC(FRAC)) u_fc (
    .v_in(v_q), .gram(g_q), .f_prev(fprev), .recip(a_q), .skip_cancel(first),
    .v_out(fc_v), .gain(fc_g), .metric(fc_m));

  mp_argmax #(.W(W), .IW(IW)) u_arg (
    .clk(clk), .rst(rst),
    .clear(state == ST_CORR || state == ST_EMIT),
    .upd_en(state == ST_SCAN && phase),
    .idx(cnt_k), .excluded(chosen[cnt_k]), .metric(fc_m), .gain(fc_g),
    .best_idx(best_idx), .best_gain(best_gain));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= 1'b0;
      first      <= 1'b1;
      cnt_k      <= '0;
      qprev      <= '0;
      smp_n      <= '0;
      np_r       <= '0;
      jcnt       <= '0;
      chosen     <= '0;
      fprev      <= '0;
      acc        <= '0;
      path_valid <= 1'b0;
      path_idx   <= '0;
      path_coef  <= '0;
      done       <= 1'b0;
    end else begin
      path_valid <= 1'b0;
      done       <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          np_r   <= (n_paths > NPW'(ND)) ? NPW'(ND) : n_paths;
          cnt_k  <= '0;
          smp_n  <= '0;
          phase  <= 1'b0;
          acc    <= '0;
          chosen <= '0;
          first  <= 1'b1;
          jcnt   <= '0;
          state  <= ST_CORR;
        end
        ST_CORR: begin
          phase <= ~phase;
          if (phase) begin
            if (smp_n == SW'(NS - 1)) begin
              acc   <= '0;
              smp_n <= '0;
              if (cnt_k == IW'(ND - 1)) begin
                cnt_k <= '0;
                state <= (np_r == '0) ? ST_FIN : ST_SCAN;
              end else begin
                cnt_k <= cnt_k + 1'b1;
              end
            end else begin
              acc   <= acc_next;
              smp_n <= smp_n + 1'b1;
            end
          end
        end
        ST_SCAN: begin
          phase <= ~phase;
          if (phase) begin
            if (cnt_k == IW'(ND - 1)) begin
              cnt_k <= '0;
              state <= ST_EMIT;
            end else begin
              cnt_k <= cnt_k + 1'b1;
            end
          end
        end
        ST_EMIT: begin
          path_valid       <= 1'b1;
          path_idx         <= best_idx;
          path_coef        <= best_gain;
          chosen[best_idx] <= 1'b1;
          qprev            <= best_idx;
          fprev            <= best_gain;
          first            <= 1'b0;
          jcnt             <= jcnt + 1'b1;
          state            <= (NPW'(jcnt + 1'b1) == np_r) ? ST_FIN : ST_SCAN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mp_estimator_chk.sv
module mp_estimator_chk #(
  parameter int ND = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          path_valid,
  input logic [IW-1:0] path_idx,
  input logic          done
);
  logic [ND-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst || done)     seen <= '0;
    else if (path_valid) seen[path_idx] <= 1'b1;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!path_valid && !done));

  p_no_repeat_r6: assert property (@(posedge clk) disable iff (rst)
    path_valid |-> !seen[path_idx]);

  p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
    path_valid |-> (int'(path_idx) < ND));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    path_valid |=> !path_valid);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_apart_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && path_valid));
endmodule

bind mp_estimator mp_estimator_chk #(.ND(ND), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .path_valid(path_valid), .path_idx(path_idx), .done(done));

// File: tb/test_mp_estimator.sv
module test_mp_estimator;
  localparam int ND   = 16;
  localparam int NS   = 32;
  localparam int W    = 10;
  localparam int FRAC = 8;
  localparam int IW   = $clog2(ND);
  localparam int NPW  = $clog2(ND + 1);
  localparam int WAW  = $clog2(NS * ND);
  localparam int HI   = 2 ** (W - 1) - 1;
  localparam int LO   = -(2 ** (W - 1));
  localparam int RUN_LIMIT = 20000;

  typedef struct packed {
    int seed; int np; int lr; int ls; int lg; int la;
  } vec_t;

  // seed, paths, sample/signal/gram/recip magnitude limits
  localparam vec_t VEC [6] = '{
    '{32'd11,  3,  60,  40, 200, 120},
    '{32'd29,  5, 120,  80, 300, 255},
    '{32'd47,  1,  30,  30, 100,  60},
    '{32'd83,  8, 200, 150, 400, 300},
    '{32'd97, 16,  80,  60, 256, 200},
    '{32'd131, 4, 511, 511, 511, 511}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, wr_en = 1'b0;
  logic [NPW-1:0] n_paths = '0;
  logic [1:0] wr_sel = '0;
  logic [WAW-1:0] wr_addr = '0;
  logic signed [W-1:0] wr_data = '0;
  logic path_valid, done;
  logic [IW-1:0] path_idx;
  logic signed [W-1:0] path_coef;

  always #4 clk = ~clk;

  mp_estimator #(.ND(ND), .NS(NS), .W(W), .FRAC(FRAC)) i_mp_estimator (
    .clk(clk), .rst(rst), .start(start), .n_paths(n_paths),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .path_valid(path_valid), .path_idx(path_idx), .path_coef(path_coef),
    .done(done));

  int checks = 0, fails = 0;
  int m_r [NS];
  int m_s [NS*ND];
  int m_g [ND*ND];
  int m_a [ND];
  int exp_idx [ND];
  int exp_coef [ND];
  int exp_n;
  int got_idx [ND];
  int got_coef [ND];
  int got_n, done_cnt;
  int unsigned rs;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int x);
    if (x > HI) return HI;
    if (x < LO) return LO;
    return x;
  endfunction

  function automatic int rnd(input int lim);
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return int'(rs % 32'(2 * lim + 1)) - lim;
  endfunction

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_addr = WAW'(addr); wr_data = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load();
    for (int n = 0; n < NS; n++) wr(0, n, m_r[n]);
    for (int x = 0; x < NS*ND; x++) wr(1, x, m_s[x]);
    for (int x = 0; x < ND*ND; x++) wr(2, x, m_g[x]);
    for (int k = 0; k < ND; k++) wr(3, k, m_a[k]);
  endtask

  // independent model from the requirement formulas
  task automatic model(input int np);
    int v [ND];
    bit ch [ND];
    int fp, qp;
    exp_n = (np > ND) ? ND : np;
    fp = 0; qp = 0;
    for (int i = 0; i < ND; i++) begin
      int s = 0;
      for (int n = 0; n < NS; n++) s += m_s[n*ND + i] * m_r[n];
      v[i] = sat(s >>> FRAC);   // R3
      ch[i] = 1'b0;
    end
    for (int j = 0; j < exp_n; j++) begin
      int bq, bi, bg;
      bit have = 1'b0;
      bq = 0; bi = 0; bg = 0;
      for (int k = 0; k < ND; k++) begin
        int g, q;
        if (j > 0) v[k] = sat(v[k] - ((fp * m_g[k*ND + qp]) >>> FRAC)); // R4
        g = sat((v[k] * m_a[k]) >>> FRAC);  // R5
        q = v[k] * g;
        if (!ch[k] && (!have || q > bq)) begin  // R6
          have = 1'b1; bq = q; bi = k; bg = g;
        end
      end
      ch[bi] = 1'b1;
      exp_idx[j] = bi; exp_coef[j] = bg;
      qp = bi; fp = bg;
    end
  endtask

  task automatic run(input int np, input bit disturb);
    int cyc = 0;
    bit fin = 1'b0;
    got_n = 0; done_cnt = 0;
    @(negedge clk);
    n_paths = NPW'(np); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
      if (path_valid && got_n < ND) begin
        got_idx[got_n] = int'(path_idx); got_coef[got_n] = int'(path_coef);
        got_n++;
      end
      if (done) begin done_cnt++; fin = 1'b1; end
      if (disturb) begin
        start = (cyc == 3) || (cyc == 900);
        wr_en = (cyc >= 5 && cyc < 5 + ND) || (cyc >= 40 && cyc < 40 + NS);
        wr_sel = (cyc < 40) ? 2'd3 : 2'd0;
        wr_addr = (cyc < 40) ? WAW'(cyc - 5) : WAW'(cyc - 40);
        wr_data = W'(-77);
      end
    end
    start = 1'b0; wr_en = 1'b0;
    if (!fin) check(1'b0, "watchdog", cyc, RUN_LIMIT);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (done) done_cnt++;
      if (path_valid) got_n++;
    end
  endtask

  task automatic compare(input string tag);
    check(got_n == exp_n, {tag, " R7 path count"}, got_n, exp_n);
    check(done_cnt == 1, {tag, " R8 done pulses"}, done_cnt, 1);
    for (int j = 0; j < exp_n && j < got_n; j++) begin
      check(got_idx[j] == exp_idx[j], {tag, " R6 index"}, got_idx[j], exp_idx[j]);
      check(got_coef[j] == exp_coef[j], {tag, " R3/R4/R5/R10 coef"},
            got_coef[j], exp_coef[j]);
    end
  endtask

  task automatic gen(input vec_t v);
    rs = 32'(v.seed) * 32'd2654435761 + 32'd1;
    for (int n = 0; n < NS; n++) m_r[n] = rnd(v.lr);
    for (int x = 0; x < NS*ND; x++) m_s[x] = rnd(v.ls);
    for (int x = 0; x < ND*ND; x++) m_g[x] = rnd(v.lg);
    for (int k = 0; k < ND; k++) m_a[k] = (rnd(v.la) + v.la) / 2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!path_valid && !done, "R1 outputs in reset", int'(path_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!path_valid && !done, "R1 outputs after reset", int'(done), 0);

    // table walk: R2 load, R3..R7 and R10 behaviour
    foreach (VEC[e]) begin
      gen(VEC[e]);
      load();
      model(VEC[e].np);
      run(VEC[e].np, 1'b0);
      compare($sformatf("vec%0d", e));
    end

    // saturated run must clamp the coefficient: R10
    begin
      bit clamp_ok = 1'b1;
      for (int j = 0; j < got_n; j++)
        if (got_coef[j] > HI || got_coef[j] < LO) clamp_ok = 1'b0;
      check(clamp_ok, "R10 coefficient range", got_n, exp_n);
    end

    // all-zero arrays: equal scores, lowest index first (R6), zero coefs
    for (int n = 0; n < NS; n++) m_r[n] = 0;
    for (int x = 0; x < NS*ND; x++) m_s[x] = 0;
    for (int x = 0; x < ND*ND; x++) m_g[x] = 0;
    for (int k = 0; k < ND; k++) m_a[k] = 0;
    load();
    model(5);
    run(5, 1'b0);
    compare("tie");
    for (int j = 0; j < 5 && j < got_n; j++)
      check(got_idx[j] == j, "R6 tie lowest index", got_idx[j], j);

    // n_paths above ND is clamped: R7/R8
    gen(VEC[1]);
    load();
    model(ND + 3);
    run(ND + 3, 1'b0);
    compare("clamp");

    // n_paths of zero: done only, R8
    run(0, 1'b0);
    check(got_n == 0, "R8 zero paths no valid", got_n, 0);
    check(done_cnt == 1, "R8 zero paths done", done_cnt, 1);

    // writes and start while busy are ignored: R2, R9
    model(6);
    run(6, 1'b1);
    compare("busy R9");
    run(6, 1'b0);
    compare("after busy writes R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 195000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule